// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block watches the four active-low strobes of a shadowed memory (nonvolatile enable, chip select, write enable, output enable) and a digital supply-good flag, and turns them into store and recall operations for a copy engine. A store moves the volatile array into the nonvolatile array; a recall moves it back. The strobes come from pins, so each one passes through a synchronizer before it is decoded, and an operation is launched only on the cycle in which the decoded condition becomes true.

Once launched, an operation runs for a fixed, parameterized number of clock cycles. During that time the strobes are ignored, the memory's data outputs are held in high impedance, and only a supply loss can interrupt it: a store in progress is abandoned and a sticky abort flag is raised. Each rise of the supply-good flag, including the first one after reset, launches a recall, so that the volatile array is reloaded before normal access resumes.

Top module: `nvseq_ctrl`

## Requirements
- R1: The store condition is nv_en_n=0, chip_sel_n=0, wr_en_n=0 and out_en_n=1; entering it with vcc_ok=1 while idle launches a store (store_start pulses, busy rises).
- R2: The recall condition is nv_en_n=0, chip_sel_n=0, out_en_n=0 and wr_en_n=1; entering it while idle launches a recall (recall_start pulses, busy rises).
- R3: Whichever of the four strobes is the last to reach its required level causes the launch; store and recall can each be entered from any of the strobes.
- R4: A condition that is still held when an operation ends does not launch another one; the decoded condition has to go false and become true again.
- R5: A store is never launched while vcc_ok=0.
- R6: If vcc_ok=0 during a store, busy falls at the next clock edge and store_aborted is set; store_aborted stays set until a later store runs to completion.
- R7: A rising edge of vcc_ok while idle (including vcc_ok already high at the first clock after reset) launches a recall; it takes priority over a strobe-decoded launch in the same cycle.
- R8: busy stays high for exactly STORE_CYCLES cycles for an uninterrupted store and RECALL_CYCLES cycles for a recall; strobe changes during busy launch nothing, including after it ends.
- R9: out_hiz is high in every cycle in which busy is high and low otherwise; both are low after reset.
- R10: A strobe change reaches the decoder after SYNC_STAGES clock edges, so with SYNC_STAGES=2 the start pulse and busy appear after the third rising edge following the change.
- R11: store_start and recall_start are single-cycle pulses, never high together, each coinciding with the first busy cycle of its operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_en_n | input | 1 | Nonvolatile enable strobe, active low, asynchronous |
| chip_sel_n | input | 1 | Chip select strobe, active low, asynchronous |
| wr_en_n | input | 1 | Write enable strobe, active low, asynchronous |
| out_en_n | input | 1 | Output enable strobe, active low, asynchronous |
| vcc_ok | input | 1 | Supply above sense threshold, synchronous to clk |
| store_start | output | 1 | One-cycle pulse launching a store in the copy engine |
| recall_start | output | 1 | One-cycle pulse launching a recall in the copy engine |
| busy | output | 1 | An operation is in progress |
| out_hiz | output | 1 | Force the memory data outputs to high impedance |
| store_aborted | output | 1 | Sticky: the last store was cut short by supply loss |

## Verification
The hardest state to reach is a supply drop in the middle of a store followed by the recovery recall, while the strobes stay parked in the store condition: the bench launches a store, lowers vcc_ok a few cycles in, raises it again and checks that only the recall runs and that the abort flag survives until a fresh store completes. Strobe edges during busy are produced by changing the condition two cycles after a recall starts and holding it to the end. Every stimulus is also replayed in a behavioural model that is compared against the outputs on each cycle.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    typedef struct packed {
        logic nv_n;
        logic ce_n;
        logic we_n;
        logic oe_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_STORE  = 2'd1,
        OP_RECALL = 2'd2
    } op_e;

    function automatic logic is_store(ctl_t c);
        return !c.nv_n && !c.ce_n && !c.we_n && c.oe_n;
    endfunction

    function automatic logic is_recall(ctl_t c);
        return !c.nv_n && !c.ce_n && c.we_n && !c.oe_n;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvseq_sync.sv
module nvseq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/nvseq_trigger.sv
module nvseq_trigger
    import nvseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    output logic trig_store,
    output logic trig_recall
);
    logic cond_store, cond_recall;
    logic prev_store, prev_recall;

    assign cond_store  = is_store(ctl);
    assign cond_recall = is_recall(ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_store  <= 1'b0;
            prev_recall <= 1'b0;
        end else begin
            prev_store  <= cond_store;
            prev_recall <= cond_recall;
        end
    end

    assign trig_store  = cond_store  && !prev_store;
    assign trig_recall = cond_recall && !prev_recall;

    p_single_store_trig_r4: assert property (@(posedge clk) disable iff (rst)
        trig_store |=> !trig_store);
    p_single_recall_trig_r4: assert property (@(posedge clk) disable iff (rst)
        trig_recall |=> !trig_recall);
endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
    import nvseq_pkg::*;
#(
    parameter int STORE_CYCLES  = 1000000,
    parameter int RECALL_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_store,
    input  logic trig_recall,
    input  logic vcc_ok,
    output logic store_start,
    output logic recall_start,
    output logic busy,
    output logic store_aborted
);
    localparam int MAXC = max2(STORE_CYCLES, RECALL_CYCLES);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ST_LOAD = CW'(STORE_CYCLES - 1);
    localparam logic [CW-1:0] RC_LOAD = CW'(RECALL_CYCLES - 1);

    op_e            state;
    logic [CW-1:0]  cnt;
    logic           vcc_prev;
    logic           vcc_rise;

    assign vcc_rise = vcc_ok && !vcc_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= OP_IDLE;
            cnt           <= '0;
            vcc_prev      <= 1'b0;
            store_start   <= 1'b0;
            recall_start  <= 1'b0;
            store_aborted <= 1'b0;
        end else begin
            vcc_prev     <= vcc_ok;
            store_start  <= 1'b0;
            recall_start <= 1'b0;
            unique case (state)
                OP_IDLE: begin
                    if (vcc_rise || trig_recall && !(trig_store && vcc_ok)) begin
                        state        <= OP_RECALL;
                        cnt          <= RC_LOAD;
                        recall_start <= 1'b1;
                    end else if (trig_store && vcc_ok) begin
                        state       <= OP_STORE;
                        cnt         <= ST_LOAD;
                        store_start <= 1'b1;
                    end
                end
                OP_STORE: begin
                    if (!vcc_ok) begin
                        state         <= OP_IDLE;
                        store_aborted <= 1'b1;
                    end else if (cnt == '0) begin
                        state         <= OP_IDLE;
                        store_aborted <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                OP_RECALL: begin
                    if (cnt == '0) state <= OP_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= OP_IDLE;
            endcase
        end
    end

    assign busy = (state != OP_IDLE);

    p_start_from_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (store_start || recall_start) |-> ($past(state) == OP_IDLE && busy));
    p_start_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_start, recall_start}));
    p_store_needs_vcc_r5: assert property (@(posedge clk) disable iff (rst)
        store_start |-> $past(vcc_ok));
    p_abort_on_loss_r6: assert property (@(posedge clk) disable iff (rst)
        (state == OP_STORE && !vcc_ok) |=> (!busy && store_aborted));
    p_busy_has_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (store_start || recall_start));
endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
    import nvseq_pkg::*;
#(
    parameter int STORE_CYCLES  = 1000000,
    parameter int RECALL_CYCLES = 2000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic nv_en_n,
    input  logic chip_sel_n,
    input  logic wr_en_n,
    input  logic out_en_n,
    input  logic vcc_ok,
    output logic store_start,
    output logic recall_start,
    output logic busy,
    output logic out_hiz,
    output logic store_aborted
);
    ctl_t raw_ctl, sync_ctl;
    logic trig_store, trig_recall;

    assign raw_ctl = '{nv_n: nv_en_n, ce_n: chip_sel_n, we_n: wr_en_n, oe_n: out_en_n};

    nvseq_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_ctl),
        .q   (sync_ctl)
    );

    nvseq_trigger u_trig (
        .clk         (clk),
        .rst         (rst),
        .ctl         (sync_ctl),
        .trig_store  (trig_store),
        .trig_recall (trig_recall)
    );

    nvseq_fsm #(.STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .trig_store    (trig_store),
        .trig_recall   (trig_recall),
        .vcc_ok        (vcc_ok),
        .store_start   (store_start),
        .recall_start  (recall_start),
        .busy          (busy),
        .store_aborted (store_aborted)
    );

    assign out_hiz = busy;

    p_hiz_follows_busy_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> out_hiz);
endmodule

// File: tb/sim_nvseq_ctrl.sv
module sim_nvseq_ctrl;
    localparam int SC = 24;
    localparam int RC = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nv_n = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic vcc = 1'b0;
    logic st_s, rc_s, bsy, hiz, abt;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    nvseq_ctrl #(.STORE_CYCLES(SC), .RECALL_CYCLES(RC), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .nv_en_n(nv_n), .chip_sel_n(ce_n), .wr_en_n(we_n),
        .out_en_n(oe_n), .vcc_ok(vcc), .store_start(st_s), .recall_start(rc_s),
        .busy(bsy), .out_hiz(hiz), .store_aborted(abt)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference: a delay queue for the strobes, an operation
    // kind with a remaining-cycle count, and remembered condition values.
    logic [3:0] pipe[$];
    int  m_kind = 0;   // 0 idle, 1 store, 2 recall
    int  m_left = 0;
    bit  m_pst = 0, m_prc = 0, m_vp = 0, m_abt = 0, m_ss = 0, m_rs = 0;

    always @(posedge clk) begin
        logic [3:0] syn;
        bit sc, rcn, ts, tr, au;
        cyc++;
        if (rst) begin
            pipe = '{4'hF, 4'hF};
            m_kind = 0; m_left = 0; m_pst = 0; m_prc = 0; m_vp = 0;
            m_abt = 0; m_ss = 0; m_rs = 0;
        end else begin
            syn = pipe[0];
            void'(pipe.pop_front());
            pipe.push_back({nv_n, ce_n, we_n, oe_n});
            sc  = (syn == 4'b0001);
            rcn = (syn == 4'b0010);
            ts  = sc && !m_pst;
            tr  = rcn && !m_prc;
            au  = vcc && !m_vp;
            m_ss = 0; m_rs = 0;
            if (m_kind == 0) begin
                if (au) begin m_kind = 2; m_left = RC - 1; m_rs = 1; end
                else if (ts && vcc) begin m_kind = 1; m_left = SC - 1; m_ss = 1; end
                else if (tr) begin m_kind = 2; m_left = RC - 1; m_rs = 1; end
            end else if (m_kind == 1 && !vcc) begin
                m_kind = 0; m_abt = 1;
            end else if (m_left == 0) begin
                if (m_kind == 1) m_abt = 0;
                m_kind = 0;
            end else begin
                m_left--;
            end
            m_pst = sc; m_prc = rcn; m_vp = vcc;
        end
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            check("R8 busy vs model", bsy, (m_kind != 0));
            check("R9 out_hiz vs model", hiz, (m_kind != 0));
            check("R11 store_start vs model", st_s, m_ss);
            check("R11 recall_start vs model", rc_s, m_rs);
            check("R6 store_aborted vs model", abt, m_abt);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(logic nv, logic ce, logic we, logic oe);
        nv_n = nv; ce_n = ce; we_n = we; oe_n = oe;
    endtask

    initial begin
        step(3);
        // R9 reset state
        check("R9 reset busy", bsy, 0);
        check("R9 reset out_hiz", hiz, 0);
        check("R11 reset pulses", st_s | rc_s, 0);
        rst = 1'b0;
        step(3);

        // R7 supply rise launches recall one edge later
        vcc = 1'b1;
        step(1);
        check("R7 recall on supply rise", rc_s, 1);
        check("R7 busy on supply rise", bsy, 1);
        step(RC + 3);

        // R1 R3 R10 store, write enable last
        ctl(0, 0, 1, 1);
        step(4);
        ctl(0, 0, 0, 1);
        step(2);
        check("R10 no start before third edge", bsy, 0);
        step(1);
        check("R1 store_start via write enable", st_s, 1);
        check("R9 out_hiz in store", hiz, 1);
        step(SC - 1);
        check("R8 store busy last cycle", bsy, 1);
        step(1);
        check("R8 store ends after STORE_CYCLES", bsy, 0);
        step(6);
        // R4 condition still held: nothing relaunches
        check("R4 held store no relaunch", bsy, 0);
        ctl(0, 0, 1, 1);
        step(4);
        ctl(0, 0, 0, 1);
        step(3);
        check("R4 fresh edge relaunches store", st_s, 1);
        step(SC + 3);

        // R2 R3 recall, output enable last
        ctl(0, 0, 1, 1);
        step(4);
        ctl(0, 0, 1, 0);
        step(3);
        check("R2 recall via output enable", rc_s, 1);
        // R8 move into store condition while busy and hold it
        step(2);
        ctl(0, 0, 0, 1);
        step(RC + 6);
        check("R8 change during busy ignored", bsy, 0);

        // R3 store with nonvolatile enable last
        ctl(1, 1, 1, 1);
        step(4);
        ctl(1, 0, 0, 1);
        step(4);
        ctl(0, 0, 0, 1);
        step(3);
        check("R3 store via nv enable", st_s, 1);
        step(SC + 3);

        // R3 recall with chip select last
        ctl(1, 1, 1, 1);
        step(4);
        ctl(0, 1, 1, 0);
        step(4);
        ctl(0, 0, 1, 0);
        step(3);
        check("R3 recall via chip select", rc_s, 1);
        step(RC + 3);

        // R5 no store with supply low
        ctl(1, 1, 1, 1);
        step(4);
        vcc = 1'b0;
        step(2);
        ctl(0, 0, 0, 1);
        step(3);
        check("R5 store blocked by low supply", bsy, 0);
        step(4);
        check("R5 still idle", bsy, 0);
        vcc = 1'b1;
        step(1);
        check("R7 recall after supply return", rc_s, 1);
        step(RC + 3);
        check("R4 held store after recall no launch", bsy, 0);

        // R6 abort in the middle of a store
        ctl(1, 1, 1, 1);
        step(4);
        ctl(0, 0, 0, 1);
        step(3);
        check("R6 store launched", st_s, 1);
        step(5);
        vcc = 1'b0;
        step(1);
        check("R6 busy drops on supply loss", bsy, 0);
        check("R6 aborted flag set", abt, 1);
        step(3);
        vcc = 1'b1;
        step(1);
        check("R7 recovery recall", rc_s, 1);
        step(RC + 3);
        check("R6 aborted flag sticky", abt, 1);
        ctl(1, 1, 1, 1);
        step(4);
        ctl(0, 0, 0, 1);
        step(3 + SC + 2);
        check("R6 aborted cleared by completed store", abt, 0);

        ctl(1, 1, 1, 1);
        step(5);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule